// File: doc/BRIEF.md
# Next-Line Prefetch Controller

This block sits beside a small direct-mapped cache and decides when to fetch the next sequential line ahead of demand. It holds the cache's tag directory. Each entry has a valid flag, an address tag and one extra "used" bit. The block sees every processor reference and works out on its own whether that reference hits. A demand miss sends a request to a memory port, and the block stalls the reference stream until that line is filled. Depending on a 2-bit policy select, the block may also request line address plus one as a prefetch. That prefetch is installed in the directory when memory answers.

Four policy settings are available. "Every" prefetches after each accepted reference. "Miss" prefetches only when a reference misses. "Tagged" prefetches when a reference misses, and also on the first use of a line that arrived by prefetch. The fourth setting turns prefetching off. The block holds at most one demand request and one prefetch at a time. A waiting demand request always takes the memory port ahead of a waiting prefetch. A prefetch is dropped when its line is already cached, or when the prefetch slot is already taken.

Top module: `nlp_ctrl`

## Requirements
- R1: After reset every directory entry is invalid, `ref_ready_o` is 1 and `mem_req_valid_o` is 0.
- R2: A reference is accepted when `ref_valid_i` and `ref_ready_o` are both 1. `ref_hit_o` is 1 in that cycle only if the line is held. A miss raises a demand request (`mem_req_pf_o`=0, `mem_req_line_o`=the line) from the next cycle. A miss also holds `ref_ready_o` at 0 until a demand response (`mem_rsp_valid_i`=1, `mem_rsp_pf_i`=0) installs the line with its used bit set.
- R3: With `mode_i`=2'b00 (every), each accepted reference, hit or miss, launches a prefetch of line+1, shown as `mem_req_pf_o`=1.
- R4: With `mode_i`=2'b01 (miss), only an accepted reference that misses launches a prefetch of line+1. A hit launches nothing.
- R5: With `mode_i`=2'b10 (tagged), a prefetch response (`mem_rsp_pf_i`=1) installs its line with the used bit clear. A hit on a line whose used bit is clear sets the bit and launches a prefetch of line+1. A hit on a line whose used bit is set launches nothing. A miss launches a prefetch of line+1.
- R6: With `mode_i`=2'b11, no prefetch is ever launched. Demand misses still work.
- R7: A prefetch is not launched when line+1 is already held in the directory.
- R8: Only one prefetch exists at a time, counted from its launch until its response. A trigger that arrives while the prefetch slot is taken is dropped, including one whose target equals the pending line.
- R9: When a demand request and a prefetch are both waiting, the port presents the demand request first. The prefetch follows once the demand request has been accepted (`mem_req_ready_i`=1).
- R10: A prefetch response for a line that is already held leaves that entry unchanged, so its used bit is not cleared.
- R11: The line+1 computation wraps modulo 2^LINE_W, so the line after the all-ones line is line 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | Policy: 00 every, 01 miss, 10 tagged, 11 off |
| ref_valid_i | input | 1 | Reference present |
| ref_line_i | input | LINE_W | Referenced line address |
| ref_ready_o | output | 1 | Reference may be accepted (no demand miss pending) |
| ref_hit_o | output | 1 | Current reference line is held |
| mem_req_valid_o | output | 1 | Memory request present |
| mem_req_ready_i | input | 1 | Memory accepts the request this cycle |
| mem_req_line_o | output | LINE_W | Requested line address |
| mem_req_pf_o | output | 1 | 1 = prefetch, 0 = demand |
| mem_rsp_valid_i | input | 1 | Memory completes an accepted request |
| mem_rsp_pf_i | input | 1 | The completed request is the prefetch (1) or the demand (0) |

## Verification
Each policy setting is driven with the same kind of sequence: a cold miss, then hits on the demand-filled line and on the prefetched line. The requests that follow separate the settings. "Every" prefetches after a hit and "miss" does not. Tagged mode is shown apart from "every" by evicting the line after a used line and then hitting that used line again: "every" would fetch the evicted line, while tagged stays quiet. A hit followed by a miss while the prefetch is still waiting shows the demand request taking the port and the second trigger being dropped. A demand for a line whose prefetch is still in flight, followed by a late prefetch response, shows that the late response leaves the used bit alone. The all-ones line address checks the wrap.

// File: rtl/nlp_pkg.sv
package nlp_pkg;

    typedef enum logic [1:0] {
        PF_EVERY  = 2'b00,
        PF_MISS   = 2'b01,
        PF_TAGGED = 2'b10,
        PF_OFF    = 2'b11
    } pf_mode_t;

endpackage

// File: rtl/nlp_dir.sv
module nlp_dir #(
    parameter int LINE_W = 16,
    parameter int SETS   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINE_W-1:0] a_line,
    output logic              a_hit,
    output logic              a_used,
    input  logic [LINE_W-1:0] b_line,
    output logic              b_hit,
    input  logic              mark_en,
    input  logic [LINE_W-1:0] mark_line,
    input  logic              fill_en,
    input  logic [LINE_W-1:0] fill_line,
    input  logic              fill_pf
);
    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = LINE_W - IDX_W;

    typedef struct packed {
        logic             vld;
        logic             used;
        logic [TAG_W-1:0] tag;
    } ent_t;

    typedef struct packed {
        ent_t [SETS-1:0] ent;
    } dir_t;

    dir_t dir_d, dir_q;

    ent_t a_ent, b_ent, f_ent;
    logic f_present;

    assign a_ent     = dir_q.ent[a_line[IDX_W-1:0]];
    assign b_ent     = dir_q.ent[b_line[IDX_W-1:0]];
    assign f_ent     = dir_q.ent[fill_line[IDX_W-1:0]];
    assign a_hit     = a_ent.vld && (a_ent.tag == a_line[LINE_W-1:IDX_W]);
    assign a_used    = a_ent.used;
    assign b_hit     = b_ent.vld && (b_ent.tag == b_line[LINE_W-1:IDX_W]);
    assign f_present = f_ent.vld && (f_ent.tag == fill_line[LINE_W-1:IDX_W]);

    always_comb begin
        dir_d = dir_q;
        if (mark_en) begin
            dir_d.ent[mark_line[IDX_W-1:0]].used = 1'b1;
        end
        // a late prefetch of a line already held must not touch it
        if (fill_en && !(fill_pf && f_present)) begin
            dir_d.ent[fill_line[IDX_W-1:0]].vld  = 1'b1;
            dir_d.ent[fill_line[IDX_W-1:0]].used = !fill_pf;
            dir_d.ent[fill_line[IDX_W-1:0]].tag  = fill_line[LINE_W-1:IDX_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= '0;
        end else begin
            dir_q <= dir_d;
        end
    end

endmodule

// File: rtl/nlp_policy.sv
module nlp_policy
    import nlp_pkg::*;
(
    input  pf_mode_t mode,
    input  logic     fire,
    input  logic     hit,
    input  logic     used,
    output logic     trig,
    output logic     mark
);
    logic first_use;

    assign first_use = fire && hit && !used;
    assign mark      = first_use;

    always_comb begin
        unique case (mode)
            PF_EVERY:  trig = fire;
            PF_MISS:   trig = fire && !hit;
            PF_TAGGED: trig = (fire && !hit) || first_use;
            default:   trig = 1'b0;
        endcase
    end

endmodule

// File: rtl/nlp_port_sel.sv
module nlp_port_sel #(
    parameter int LINE_W = 16
) (
    input  logic              dem_wait,
    input  logic [LINE_W-1:0] dem_line,
    input  logic              pf_wait,
    input  logic [LINE_W-1:0] pf_line,
    input  logic              ready,
    output logic              req_valid,
    output logic [LINE_W-1:0] req_line,
    output logic              req_pf,
    output logic              grant_dem,
    output logic              grant_pf
);
    assign req_valid = dem_wait || pf_wait;
    assign req_pf    = !dem_wait;
    assign req_line  = dem_wait ? dem_line : pf_line;
    assign grant_dem = ready && dem_wait;
    assign grant_pf  = ready && !dem_wait && pf_wait;

endmodule

// File: rtl/nlp_ctrl.sv
module nlp_ctrl
    import nlp_pkg::*;
#(
    parameter int LINE_W = 16,
    parameter int SETS   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_i,
    input  logic              ref_valid_i,
    input  logic [LINE_W-1:0] ref_line_i,
    output logic              ref_ready_o,
    output logic              ref_hit_o,
    output logic              mem_req_valid_o,
    input  logic              mem_req_ready_i,
    output logic [LINE_W-1:0] mem_req_line_o,
    output logic              mem_req_pf_o,
    input  logic              mem_rsp_valid_i,
    input  logic              mem_rsp_pf_i
);
    typedef struct packed {
        logic              dem_valid;
        logic              dem_sent;
        logic [LINE_W-1:0] dem_line;
        logic              pf_valid;
        logic              pf_sent;
        logic [LINE_W-1:0] pf_line;
    } slots_t;

    slots_t s_d, s_q;

    logic              fire, a_hit, a_used, b_hit;
    logic              trig, mark, launch;
    logic [LINE_W-1:0] cand;
    logic              grant_dem, grant_pf;
    logic              dem_done, pf_done;
    logic              fill_en, fill_pf;
    logic [LINE_W-1:0] fill_line;

    // visible to the bound checker
    logic dem_pend, dem_sent, pf_pend, pf_sent;
    logic [LINE_W-1:0] pf_line;

    assign fire        = ref_valid_i && ref_ready_o;
    assign ref_ready_o = !s_q.dem_valid;
    assign ref_hit_o   = a_hit;
    assign cand        = ref_line_i + LINE_W'(1);

    assign dem_done = mem_rsp_valid_i && !mem_rsp_pf_i && s_q.dem_valid && s_q.dem_sent;
    assign pf_done  = mem_rsp_valid_i &&  mem_rsp_pf_i && s_q.pf_valid  && s_q.pf_sent;

    assign fill_en   = dem_done || pf_done;
    assign fill_pf   = pf_done;
    assign fill_line = pf_done ? s_q.pf_line : s_q.dem_line;

    // a held target or a taken slot drops the trigger
    assign launch = trig && !b_hit && !s_q.pf_valid;

    nlp_dir #(.LINE_W(LINE_W), .SETS(SETS)) i_dir (
        .clk       (clk),
        .rst_n     (rst_n),
        .a_line    (ref_line_i),
        .a_hit     (a_hit),
        .a_used    (a_used),
        .b_line    (cand),
        .b_hit     (b_hit),
        .mark_en   (mark),
        .mark_line (ref_line_i),
        .fill_en   (fill_en),
        .fill_line (fill_line),
        .fill_pf   (fill_pf)
    );

    nlp_policy i_policy (
        .mode (pf_mode_t'(mode_i)),
        .fire (fire),
        .hit  (a_hit),
        .used (a_used),
        .trig (trig),
        .mark (mark)
    );

    nlp_port_sel #(.LINE_W(LINE_W)) i_port (
        .dem_wait  (s_q.dem_valid && !s_q.dem_sent),
        .dem_line  (s_q.dem_line),
        .pf_wait   (s_q.pf_valid && !s_q.pf_sent),
        .pf_line   (s_q.pf_line),
        .ready     (mem_req_ready_i),
        .req_valid (mem_req_valid_o),
        .req_line  (mem_req_line_o),
        .req_pf    (mem_req_pf_o),
        .grant_dem (grant_dem),
        .grant_pf  (grant_pf)
    );

    always_comb begin
        s_d = s_q;
        if (grant_dem) s_d.dem_sent = 1'b1;
        if (grant_pf)  s_d.pf_sent  = 1'b1;
        if (dem_done) begin
            s_d.dem_valid = 1'b0;
            s_d.dem_sent  = 1'b0;
        end
        if (pf_done) begin
            s_d.pf_valid = 1'b0;
            s_d.pf_sent  = 1'b0;
        end
        if (fire && !a_hit) begin
            s_d.dem_valid = 1'b1;
            s_d.dem_sent  = 1'b0;
            s_d.dem_line  = ref_line_i;
        end
        if (launch) begin
            s_d.pf_valid = 1'b1;
            s_d.pf_sent  = 1'b0;
            s_d.pf_line  = cand;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign dem_pend = s_q.dem_valid;
    assign dem_sent = s_q.dem_sent;
    assign pf_pend  = s_q.pf_valid;
    assign pf_sent  = s_q.pf_sent;
    assign pf_line  = s_q.pf_line;

endmodule

// File: rtl/nlp_ctrl_chk.sv
module nlp_ctrl_chk #(
    parameter int LINE_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        mode_i,
    input logic [LINE_W-1:0] ref_line_i,
    input logic              ref_ready_o,
    input logic              mem_req_valid_o,
    input logic              mem_req_pf_o,
    input logic              mem_rsp_valid_i,
    input logic              mem_rsp_pf_i,
    input logic              dem_pend,
    input logic              dem_sent,
    input logic              pf_pend,
    input logic              pf_sent,
    input logic [LINE_W-1:0] pf_line
);
    // R2: a demand request on the port means references are stalled
    a_r2_demand_stalls: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid_o && !mem_req_pf_o) |-> !ref_ready_o);

    // R9: a waiting demand request owns the port
    a_r9_demand_first: assert property (@(posedge clk) disable iff (!rst_n)
        (dem_pend && !dem_sent) |-> (mem_req_valid_o && !mem_req_pf_o));

    // R6: with prefetch off an idle slot stays idle
    a_r6_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'b11 && !pf_pend) |=> !pf_pend);

    // R3/R11: a newly launched prefetch targets the previous reference plus one
    a_r11_next_line: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pf_pend) |-> (pf_line == LINE_W'($past(ref_line_i) + 1'b1)));

    // R8: an outstanding prefetch keeps its line until its response
    a_r8_single_pf: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_pend && !(mem_rsp_valid_i && mem_rsp_pf_i && pf_sent))
            |=> (pf_pend && $stable(pf_line)));

endmodule

bind nlp_ctrl nlp_ctrl_chk #(.LINE_W(LINE_W)) i_nlp_ctrl_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .mode_i          (mode_i),
    .ref_line_i      (ref_line_i),
    .ref_ready_o     (ref_ready_o),
    .mem_req_valid_o (mem_req_valid_o),
    .mem_req_pf_o    (mem_req_pf_o),
    .mem_rsp_valid_i (mem_rsp_valid_i),
    .mem_rsp_pf_i    (mem_rsp_pf_i),
    .dem_pend        (dem_pend),
    .dem_sent        (dem_sent),
    .pf_pend         (pf_pend),
    .pf_sent         (pf_sent),
    .pf_line         (pf_line)
);

// File: tb/test_nlp_ctrl.sv
`timescale 1ns/1ps
module test_nlp_ctrl;
    localparam int LINE_W = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        mode_i = 2'b00;
    logic              ref_valid_i = 1'b0;
    logic [LINE_W-1:0] ref_line_i = '0;
    logic              ref_ready_o, ref_hit_o;
    logic              mem_req_valid_o, mem_req_pf_o;
    logic [LINE_W-1:0] mem_req_line_o;
    logic              mem_req_ready_i = 1'b0;
    logic              mem_rsp_valid_i = 1'b0;
    logic              mem_rsp_pf_i = 1'b0;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    nlp_ctrl #(.LINE_W(LINE_W), .SETS(8)) i_nlp_ctrl (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i),
        .ref_valid_i(ref_valid_i), .ref_line_i(ref_line_i),
        .ref_ready_o(ref_ready_o), .ref_hit_o(ref_hit_o),
        .mem_req_valid_o(mem_req_valid_o), .mem_req_ready_i(mem_req_ready_i),
        .mem_req_line_o(mem_req_line_o), .mem_req_pf_o(mem_req_pf_o),
        .mem_rsp_valid_i(mem_rsp_valid_i), .mem_rsp_pf_i(mem_rsp_pf_i)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] mode);
        @(negedge clk);
        rst_n = 1'b0;
        mode_i = mode;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 ready after reset", 32'(ref_ready_o), 32'd1);
        check("R1 no request after reset", 32'(mem_req_valid_o), 32'd0);
    endtask

    task automatic do_ref(input logic [LINE_W-1:0] line, input logic exp_hit, input string tag);
        ref_valid_i = 1'b1;
        ref_line_i  = line;
        #1;
        check({tag, " ready"}, 32'(ref_ready_o), 32'd1);
        check({tag, " hit"}, 32'(ref_hit_o), 32'(exp_hit));
        @(posedge clk);
        @(negedge clk);
        ref_valid_i = 1'b0;
        #1;
    endtask

    task automatic exp_req(input logic v, input logic [LINE_W-1:0] line, input logic pf, input string tag);
        check({tag, " req valid"}, 32'(mem_req_valid_o), 32'(v));
        if (v) begin
            check({tag, " req line"}, 32'(mem_req_line_o), 32'(line));
            check({tag, " req kind"}, 32'(mem_req_pf_o), 32'(pf));
        end
    endtask

    task automatic grant;
        mem_req_ready_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        mem_req_ready_i = 1'b0;
        #1;
    endtask

    task automatic respond(input logic pf);
        mem_rsp_valid_i = 1'b1;
        mem_rsp_pf_i    = pf;
        @(posedge clk);
        @(negedge clk);
        mem_rsp_valid_i = 1'b0;
        #1;
    endtask

    task automatic t_every;
        do_reset(2'b00);
        do_ref(16'd10, 1'b0, "R2 cold miss");
        exp_req(1'b1, 16'd10, 1'b0, "R2 demand issued");
        check("R2 stall during miss", 32'(ref_ready_o), 32'd0);
        grant();
        exp_req(1'b1, 16'd11, 1'b1, "R3 prefetch after miss");
        grant();
        exp_req(1'b0, '0, 1'b0, "R8 nothing more");
        respond(1'b0);
        check("R2 ready after fill", 32'(ref_ready_o), 32'd1);
        respond(1'b1);
        do_ref(16'd10, 1'b1, "R2 hit after fill");
        exp_req(1'b0, '0, 1'b0, "R7 target held");
        do_ref(16'd11, 1'b1, "R3 hit prefetched");
        exp_req(1'b1, 16'd12, 1'b1, "R3 prefetch after hit");
        do_ref(16'd30, 1'b0, "R9 miss with pf waiting");
        exp_req(1'b1, 16'd30, 1'b0, "R9 demand first");
        grant();
        exp_req(1'b1, 16'd12, 1'b1, "R8 older prefetch kept");
        grant();
        exp_req(1'b0, '0, 1'b0, "R8 second trigger dropped");
        respond(1'b0);
        respond(1'b1);
    endtask

    task automatic t_miss;
        do_reset(2'b01);
        do_ref(16'd20, 1'b0, "R4 cold miss");
        exp_req(1'b1, 16'd20, 1'b0, "R4 demand");
        grant();
        exp_req(1'b1, 16'd21, 1'b1, "R4 prefetch on miss");
        grant();
        respond(1'b0);
        respond(1'b1);
        do_ref(16'd21, 1'b1, "R4 hit");
        exp_req(1'b0, '0, 1'b0, "R4 no prefetch on hit");
        do_ref(16'd22, 1'b0, "R4 second miss");
        grant();
        exp_req(1'b1, 16'd23, 1'b1, "R4 prefetch on second miss");
        grant();
        respond(1'b0);
        respond(1'b1);
    endtask

    task automatic t_tagged;
        do_reset(2'b10);
        do_ref(16'd40, 1'b0, "R5 cold miss");
        grant();
        exp_req(1'b1, 16'd41, 1'b1, "R5 prefetch on miss");
        grant();
        respond(1'b0);
        respond(1'b1);
        do_ref(16'd41, 1'b1, "R5 first use");
        exp_req(1'b1, 16'd42, 1'b1, "R5 prefetch on first use");
        grant();
        respond(1'b1);
        do_ref(16'd42, 1'b1, "R5 first use 42");
        exp_req(1'b1, 16'd43, 1'b1, "R5 prefetch 43");
        grant();
        respond(1'b1);
        do_ref(16'd51, 1'b0, "R5 evict 43");
        exp_req(1'b1, 16'd51, 1'b0, "R5 demand 51");
        grant();
        exp_req(1'b1, 16'd52, 1'b1, "R5 prefetch 52");
        grant();
        respond(1'b0);
        respond(1'b1);
        do_ref(16'd42, 1'b1, "R5 reuse 42");
        exp_req(1'b0, '0, 1'b0, "R5 used line quiet");
    endtask

    task automatic t_late_fill;
        do_reset(2'b10);
        do_ref(16'd100, 1'b0, "R10 cold miss");
        grant();
        exp_req(1'b1, 16'd101, 1'b1, "R10 prefetch 101");
        grant();
        respond(1'b0);
        do_ref(16'd101, 1'b0, "R10 miss in flight");
        exp_req(1'b1, 16'd101, 1'b0, "R10 demand 101");
        grant();
        exp_req(1'b0, '0, 1'b0, "R8 slot taken drops 102");
        respond(1'b0);
        respond(1'b1);
        do_ref(16'd101, 1'b1, "R10 hit after late fill");
        exp_req(1'b0, '0, 1'b0, "R10 used bit kept");
    endtask

    task automatic t_off;
        do_reset(2'b11);
        do_ref(16'd60, 1'b0, "R6 miss");
        exp_req(1'b1, 16'd60, 1'b0, "R6 demand");
        grant();
        exp_req(1'b0, '0, 1'b0, "R6 no prefetch");
        respond(1'b0);
        do_ref(16'd60, 1'b1, "R6 hit");
        exp_req(1'b0, '0, 1'b0, "R6 no prefetch on hit");
    endtask

    task automatic t_wrap;
        do_reset(2'b00);
        do_ref(16'hFFFF, 1'b0, "R11 top line miss");
        exp_req(1'b1, 16'hFFFF, 1'b0, "R11 demand");
        grant();
        exp_req(1'b1, 16'h0000, 1'b1, "R11 wrapped prefetch");
        grant();
        respond(1'b0);
        respond(1'b1);
        do_ref(16'h0000, 1'b1, "R11 line 0 held");
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_every();
        t_miss();
        t_tagged();
        t_late_fill();
        t_off();
        t_wrap();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule